// File: doc/BRIEF.md
# Start-Delimiter Symbol Pair Framer

This block sits on the receive side of a symbol-serial link. It takes one 5-bit line symbol on every receive clock cycle and works out where each symbol pair begins. The boundary is not fixed in advance. The block finds it by watching for the two-symbol start pattern: a J symbol followed directly by a K symbol. The J symbol then becomes the high half of a pair.

Once the block has found a boundary, it joins each two consecutive symbols into one 10-bit pair. It presents each pair with a one-cycle valid strobe, together with a sticky `aligned` status. The start pattern may show up later at the opposite symbol offset. When that happens, the block moves its boundary at once. It discards the half-built pair and restarts the output with the start pattern itself.

Clock recovery, crossing into a local clock domain and symbol decoding are left to neighbouring blocks.

Top module: `sd_pair_framer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pair_valid` is 0, `aligned` is 0 and `pair_out` is 0.
- R2: Until the first start pattern has been seen, `pair_valid` and `aligned` stay 0 whatever symbols arrive.
- R3: The start pattern is J = 5'b11000 sampled on one cycle, followed by K = 5'b10001 sampled on the next cycle. On the clock edge that samples K, the outputs change so that `pair_valid`=1, `pair_out`=10'b11000_10001 (J in bits 9:5, K in bits 4:0) and `aligned`=1.
- R4: While aligned, the block emits one pair for every two input symbols. The earlier symbol goes in bits 9:5 and the later symbol in bits 4:0. `pair_valid` is high on every second cycle only.
- R5: Once `aligned` is 1, it stays 1 until reset.
- R6: A start pattern whose J was the low half of a pair already emitted moves the boundary at once. The pair {J,K} is emitted on the very next edge. The symbol that would have started a new pair is discarded, and pairing carries on from the symbol after K.
- R7: A start pattern that falls on the current boundary is emitted as an ordinary pair, and the cadence of the pairs is unchanged.
- R8: A J that is not followed by K, or a K that is not preceded by J, does not align the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 5 | Line symbol, one per cycle |
| pair_out | output | 10 | Assembled symbol pair, earlier symbol in the high half |
| pair_valid | output | 1 | One-cycle strobe marking a new pair on `pair_out` |
| aligned | output | 1 | High once a pair boundary has been established |

## Verification
The assertions check several rules on every cycle. A strobe never appears without alignment. Alignment never drops. Each start pattern seen at the input yields a {J,K} pair on the next edge. Two strobes in a row happen only when the second pair is the start pattern. Only the bench scenarios can show the rest. These are the exact pairing of ordinary data symbols and the cadence after a boundary move. They also show that near-misses of the pattern are ignored and that the discarded half-pair never reaches the output.

// File: rtl/sd_framer_pkg.sv
package sd_framer_pkg;
  localparam int DEF_SYM_W = 5;
  localparam logic [DEF_SYM_W-1:0] DEF_J_CODE = 5'b11000;
  localparam logic [DEF_SYM_W-1:0] DEF_K_CODE = 5'b10001;
endpackage

// File: rtl/sd_sym_history.sv
module sd_sym_history #(
  parameter int SYM_W = 5,
  parameter logic [SYM_W-1:0] J_CODE = 5'b11000,
  parameter logic [SYM_W-1:0] K_CODE = 5'b10001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] prev_sym,
  output logic             jk_hit
);
  always_ff @(posedge clk) begin
    if (rst) prev_sym <= '0;
    else     prev_sym <= sym_in;
  end

  always_comb jk_hit = (prev_sym == J_CODE) && (sym_in == K_CODE);
endmodule

// File: rtl/sd_align_ctrl.sv
module sd_align_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic jk_hit,
  output logic aligned,
  output logic take_pair
);
  logic want_low;

  always_comb take_pair = jk_hit || (aligned && want_low);

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned  <= 1'b0;
      want_low <= 1'b0;
    end else if (jk_hit) begin
      aligned  <= 1'b1;
      want_low <= 1'b0;
    end else if (aligned) begin
      want_low <= ~want_low;
    end
  end

  // R5
  aligned_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    aligned |=> aligned);
endmodule

// File: rtl/sd_pair_pack.sv
module sd_pair_pack #(
  parameter int SYM_W = 5,
  localparam int PAIR_W = 2 * SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_pair,
  input  logic [SYM_W-1:0]  hi_sym,
  input  logic [SYM_W-1:0]  lo_sym,
  output logic [PAIR_W-1:0] pair_out,
  output logic              pair_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_out   <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= take_pair;
      if (take_pair) pair_out <= {hi_sym, lo_sym};
    end
  end
endmodule

// File: rtl/sd_pair_framer.sv
module sd_pair_framer
  import sd_framer_pkg::*;
#(
  parameter int SYM_W = DEF_SYM_W,
  parameter logic [SYM_W-1:0] J_CODE = DEF_J_CODE,
  parameter logic [SYM_W-1:0] K_CODE = DEF_K_CODE,
  localparam int PAIR_W = 2 * SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SYM_W-1:0]  sym_in,
  output logic [PAIR_W-1:0] pair_out,
  output logic              pair_valid,
  output logic              aligned
);
  logic [SYM_W-1:0] prev_sym;
  logic             jk_hit;
  logic             take_pair;

  sd_sym_history #(.SYM_W(SYM_W), .J_CODE(J_CODE), .K_CODE(K_CODE)) u_hist (
    .clk(clk), .rst(rst), .sym_in(sym_in), .prev_sym(prev_sym), .jk_hit(jk_hit)
  );

  sd_align_ctrl u_ctrl (
    .clk(clk), .rst(rst), .jk_hit(jk_hit), .aligned(aligned), .take_pair(take_pair)
  );

  sd_pair_pack #(.SYM_W(SYM_W)) u_pack (
    .clk(clk), .rst(rst), .take_pair(take_pair), .hi_sym(prev_sym), .lo_sym(sym_in),
    .pair_out(pair_out), .pair_valid(pair_valid)
  );

  // R2
  valid_needs_align_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> aligned);

  // R3
  jk_emits_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_sym == J_CODE && sym_in == K_CODE) |=> (pair_valid && aligned && pair_out == {J_CODE, K_CODE}));

  // R3
  align_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> (pair_valid && pair_out == {J_CODE, K_CODE}));

  // R4
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && $past(pair_valid)) |-> (pair_out == {J_CODE, K_CODE}));
endmodule

// File: tb/tb_sd_pair_framer.sv
`timescale 1ns/1ps
module tb_sd_pair_framer;
  localparam logic [4:0] JS = 5'b11000;
  localparam logic [4:0] KS = 5'b10001;
  localparam logic [4:0] IS = 5'b11111;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] sym_in = 5'b00000;
  logic [9:0] pair_out;
  logic       pair_valid;
  logic       aligned;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_pair_framer dut (
    .clk(clk), .rst(rst), .sym_in(sym_in),
    .pair_out(pair_out), .pair_valid(pair_valid), .aligned(aligned)
  );

  task automatic chk(input string tag, input bit ev, input bit ea, input logic [9:0] ed);
    logic [11:0] act, exp;
    act = {pair_valid, aligned, ev ? pair_out : 10'h000};
    exp = {ev, ea, ed};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual valid=%0b aligned=%0b pair=%b expected valid=%0b aligned=%0b pair=%b",
               tag, act[11], act[10], act[9:0], exp[11], exp[10], exp[9:0]);
    end
  endtask

  task automatic push(input logic [4:0] s);
    sym_in = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sym_in = 5'b00000;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 during reset", 0, 0, 10'h000);
    total++;
    if (pair_out !== 10'h000) begin
      bad++;
      $display("FAIL R1 pair_out: actual=%b expected=%b", pair_out, 10'h000);
    end
    rst = 1'b0;
    push(5'b00000);
    chk("R1 first cycle after reset", 0, 0, 10'h000);
  endtask

  task automatic t_near_miss();
    push(IS); chk("R2 idle", 0, 0, 0);
    push(JS); chk("R2 lone J", 0, 0, 0);
    push(IS); chk("R8 J then idle", 0, 0, 0);
    push(KS); chk("R8 K without J", 0, 0, 0);
    push(JS); chk("R8 J", 0, 0, 0);
    push(JS); chk("R8 J then J", 0, 0, 0);
    push(5'b01010); chk("R8 J then data", 0, 0, 0);
  endtask

  task automatic t_first_align();
    push(JS); chk("R2 J before K", 0, 0, 0);
    push(KS); chk("R3 first start pattern", 1, 1, {JS, KS});
    push(5'b00111); chk("R4 high half", 0, 1, 0);
    push(5'b01001); chk("R4 pair A", 1, 1, {5'b00111, 5'b01001});
    push(5'b10100); chk("R4 high half", 0, 1, 0);
    push(5'b10101); chk("R4 pair B", 1, 1, {5'b10100, 5'b10101});
    push(IS); chk("R5 still aligned", 0, 1, 0);
    push(IS); chk("R4 idle pair", 1, 1, {IS, IS});
  endtask

  task automatic t_same_offset();
    push(JS); chk("R7 J high half", 0, 1, 0);
    push(KS); chk("R7 start on boundary", 1, 1, {JS, KS});
    push(5'b01110); chk("R7 cadence high", 0, 1, 0);
    push(5'b01111); chk("R7 cadence pair", 1, 1, {5'b01110, 5'b01111});
  endtask

  task automatic t_opposite_offset();
    push(5'b11100); chk("R6 high half", 0, 1, 0);
    push(JS); chk("R6 pair ending in J", 1, 1, {5'b11100, JS});
    push(KS); chk("R6 realign emits JK", 1, 1, {JS, KS});
    push(5'b10010); chk("R6 new high half", 0, 1, 0);
    push(5'b10011); chk("R6 new offset pair", 1, 1, {5'b10010, 5'b10011});
    push(5'b11010); chk("R5 aligned kept", 0, 1, 0);
    push(5'b11011); chk("R6 cadence holds", 1, 1, {5'b11010, 5'b11011});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_near_miss();
    t_first_align();
    t_same_offset();
    t_opposite_offset();
    do_reset();
    t_near_miss();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule